// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block arbitrates among 63 interrupt request lines and tells the processor which interrupt level to take. Lines 1 to 7 are fixed requests. Each of them sits permanently at the level equal to its number. Lines 8 to 63 are programmable. Software gives each of them a level from 1 to 7 and a priority from 0 to 7 within that level. A programmable line whose level is still 0 takes no part in arbitration. A 64-bit mask blocks single lines, and mask bit 0 blocks everything.

Every pending, unmasked and enabled line is ranked first by its level and then by its priority. Inside a level, the fixed line takes a slot between programmable priorities 4 and 3. The highest pending level goes to the core on `core_level`, which is 0 when nothing is pending. The core answers with an acknowledge strobe. The strobe carries either the level being served (1 to 7) or 0 for a software-generic acknowledge across all levels. One cycle later the block returns the vector of the winning line, or a spurious vector if that level has nothing pending.

Top module: `prio_intc`

## Requirements
- R1: After reset, `core_level` is 0, `ack_valid` is 0, every programmable line has level 0, and all 64 mask bits are set, so raised requests produce no level.
- R2: `core_level` equals the highest level among pending, unmasked, enabled lines, or 0 if there are none, one clock after the inputs change.
- R3: Line n (1 to 7) always has level n. Within that level it ranks below programmable priorities 7 to 4 and above priorities 3 to 0.
- R4: An acknowledge with `ack_lvl` L (1 to 7) returns, one clock after the `ack_stb` cycle, `ack_vector` = 64 + the number of the best line pending at level L.
- R5: An acknowledge that finds no eligible line returns the spurious vector 0x18.
- R6: An acknowledge with `ack_lvl` = 0 returns 64 + the number of the best line over all levels, ranked by level first and then by priority.
- R7: A set bit n in the mask removes line n from arbitration. A set mask bit 0 removes every line.
- R8: When two eligible lines have equal level and equal rank, the line with the lower number wins.
- R9: Configuration writes to lines 0 to 7 are ignored. A programmable line with level 0 is never eligible.
- R10: `ack_valid` is high for exactly the one cycle after each `ack_stb` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 64 | Request lines, bit 0 unused |
| cfg_we | input | 1 | Write level and priority of one line |
| cfg_src | input | 6 | Line number being configured |
| cfg_level | input | 3 | Level to write (0 disables) |
| cfg_prio | input | 3 | Priority to write |
| mask_we | input | 1 | Write the mask |
| mask_wdata | input | 64 | New mask value |
| ack_stb | input | 1 | Acknowledge read request |
| ack_lvl | input | 3 | Level acknowledged, 0 for generic |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_vector | output | 8 | Returned vector |
| core_level | output | 3 | Highest pending level |

## Verification
A stale or corrupted level or priority register shows up in the next acknowledge of the affected level as the wrong vector. If it moves a line to a higher level than any other, `core_level` also goes wrong one clock after the request. A broken mask bit or a broken global mask shows within one clock on `core_level` or in the next acknowledge. An ordering error at the midpoint slot or in the tie rule shows only when two eligible lines share a level, so the bench builds those pairs directly and also lets random configurations create them.

// File: rtl/intc_pkg.sv
// Package: shared sizes and constants for the leveled interrupt controller.
// Assumes a power-of-two level field whose maximum value gives the count of
// fixed lines (levels 1..2**LVL_W-1).
package intc_pkg;
    localparam int NSRC       = 64;
    localparam int SRC_W      = $clog2(NSRC);
    localparam int LVL_W      = 3;
    localparam int PRI_W      = 3;
    localparam int FIRST_PROG = 1 << LVL_W;          // first programmable line
    localparam int RANK_W     = PRI_W + 1;           // priorities plus midpoint slot
    localparam int KEY_W      = LVL_W + RANK_W;
    localparam int MID_RANK   = 1 << (PRI_W - 1);    // slot between prio 4 and 3
    localparam int VEC_W      = 8;
    localparam int VEC_BASE   = 64;
    localparam logic [VEC_W-1:0] VEC_SPURIOUS = 8'h18;
endpackage

// File: rtl/intc_cfg_regs.sv
// Module: holds level/priority of every programmable line and the mask.
// Assumes: lines below FIRST_PROG have no storage; writes to them are dropped.
module intc_cfg_regs
    import intc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [SRC_W-1:0]            cfg_src,
    input  logic [LVL_W-1:0]            cfg_level,
    input  logic [PRI_W-1:0]            cfg_prio,
    input  logic                        mask_we,
    input  logic [N-1:0]                mask_wdata,
    output logic [N-1:0][LVL_W-1:0]     lvl_q,
    output logic [N-1:0][PRI_W-1:0]     pri_q,
    output logic [N-1:0]                mask_q
);
    for (genvar n = 0; n < N; n++) begin : g_src
        if (n < FIRST_PROG) begin : g_fixed
            assign lvl_q[n] = '0;
            assign pri_q[n] = '0;
        end else begin : g_prog
            // Per-line control register, cleared to level 0 (disabled) on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lvl_q[n] <= '0;
                    pri_q[n] <= '0;
                end else if (cfg_we && cfg_src == SRC_W'(n)) begin
                    lvl_q[n] <= cfg_level;
                    pri_q[n] <= cfg_prio;
                end
            end
        end
    end

    // Mask register, all lines blocked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_we) mask_q <= mask_wdata;
    end
endmodule

// File: rtl/intc_key_build.sv
// Module: forms eligibility and a {level, rank} sort key for every line.
// Assumes: rank inserts the fixed line at MID_RANK, shifting priorities
// at or above MID_RANK up by one.
module intc_key_build
    import intc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]                irq_req,
    input  logic [N-1:0][LVL_W-1:0]     lvl_q,
    input  logic [N-1:0][PRI_W-1:0]     pri_q,
    input  logic [N-1:0]                mask_q,
    output logic [N-1:0]                active,
    output logic [N-1:0][KEY_W-1:0]     key
);
    for (genvar n = 0; n < N; n++) begin : g_key
        if (n == 0) begin : g_none
            assign active[n] = 1'b0;
            assign key[n]    = '0;
        end else if (n < FIRST_PROG) begin : g_fixed
            assign active[n] = irq_req[n] & ~mask_q[n] & ~mask_q[0];
            assign key[n]    = {LVL_W'(n), RANK_W'(MID_RANK)};
        end else begin : g_prog
            logic [RANK_W-1:0] rank;
            // Open the midpoint slot by lifting upper priorities one step.
            always_comb begin
                rank = {1'b0, pri_q[n]};
                if (pri_q[n] >= PRI_W'(MID_RANK)) rank = rank + 1'b1;
            end
            assign active[n] = irq_req[n] & ~mask_q[n] & ~mask_q[0] & (|lvl_q[n]);
            assign key[n]    = {lvl_q[n], rank};
        end
    end
endmodule

// File: rtl/intc_pick.sv
// Module: selects the eligible line with the largest key, optionally only
// inside one level (filt_lvl = 0 means all levels).
// Assumes: equal keys resolve to the lower line number (strict compare,
// ascending scan).
module intc_pick
    import intc_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]                active,
    input  logic [N-1:0][KEY_W-1:0]     key,
    input  logic [LVL_W-1:0]            filt_lvl,
    output logic                        found,
    output logic [SRC_W-1:0]            win_idx,
    output logic [KEY_W-1:0]            win_key
);
    // Ascending scan keeping the first line with the largest key.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_key = '0;
        for (int i = 0; i < N; i++) begin
            if (active[i] &&
                (filt_lvl == '0 || key[i][KEY_W-1 -: LVL_W] == filt_lvl) &&
                (!found || key[i] > win_key)) begin
                found   = 1'b1;
                win_idx = SRC_W'(i);
                win_key = key[i];
            end
        end
    end
endmodule

// File: rtl/prio_intc.sv
// Module: top of the leveled interrupt controller. Drives the highest pending
// level to the core and answers acknowledge strobes with a vector one clock
// later.
// Assumes: ack_lvl 0 selects the software-generic acknowledge.
module prio_intc
    import intc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     irq_req,
    input  logic                cfg_we,
    input  logic [SRC_W-1:0]    cfg_src,
    input  logic [LVL_W-1:0]    cfg_level,
    input  logic [PRI_W-1:0]    cfg_prio,
    input  logic                mask_we,
    input  logic [NSRC-1:0]     mask_wdata,
    input  logic                ack_stb,
    input  logic [LVL_W-1:0]    ack_lvl,
    output logic                ack_valid,
    output logic [VEC_W-1:0]    ack_vector,
    output logic [LVL_W-1:0]    core_level
);
    logic [NSRC-1:0][LVL_W-1:0] lvl_q;
    logic [NSRC-1:0][PRI_W-1:0] pri_q;
    logic [NSRC-1:0]            mask_q;
    logic [NSRC-1:0]            act;
    logic [NSRC-1:0][KEY_W-1:0] key;
    logic                       all_found, lv_found;
    logic [SRC_W-1:0]           all_idx, lv_idx;
    logic [KEY_W-1:0]           all_key, lv_key;

    intc_cfg_regs #(.N(NSRC)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_level(cfg_level), .cfg_prio(cfg_prio),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .lvl_q(lvl_q), .pri_q(pri_q), .mask_q(mask_q)
    );

    intc_key_build #(.N(NSRC)) u_keys (
        .irq_req(irq_req), .lvl_q(lvl_q), .pri_q(pri_q), .mask_q(mask_q),
        .active(act), .key(key)
    );

    intc_pick #(.N(NSRC)) u_pick_all (
        .active(act), .key(key), .filt_lvl('0),
        .found(all_found), .win_idx(all_idx), .win_key(all_key)
    );

    intc_pick #(.N(NSRC)) u_pick_ack (
        .active(act), .key(key), .filt_lvl(ack_lvl),
        .found(lv_found), .win_idx(lv_idx), .win_key(lv_key)
    );

    // Register the level presented to the core.
    always_ff @(posedge clk) begin
        if (!rst_n)         core_level <= '0;
        else if (all_found) core_level <= all_key[KEY_W-1 -: LVL_W];
        else                core_level <= '0;
    end

    // Capture the acknowledge answer one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid  <= 1'b0;
            ack_vector <= '0;
        end else begin
            ack_valid <= ack_stb;
            if (ack_stb)
                ack_vector <= lv_found ? VEC_W'(VEC_BASE) + VEC_W'(lv_idx) : VEC_SPURIOUS;
        end
    end
endmodule

// File: rtl/prio_intc_chk.sv
// Checker: temporal properties of the controller, bound into prio_intc.
module prio_intc_chk
    import intc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ack_stb,
    input logic                 ack_valid,
    input logic [VEC_W-1:0]     ack_vector,
    input logic [LVL_W-1:0]     core_level,
    input logic [NSRC-1:0]      act,
    input logic [NSRC-1:0]      mask_q
);
    p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == '0) |=> (core_level == '0));

    p_fixed_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act[FIRST_PROG-1] |=> (core_level == LVL_W'(FIRST_PROG-1)));

    p_vec_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_vector != VEC_SPURIOUS) |-> (ack_vector >= VEC_W'(VEC_BASE)));

    p_mask_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[0] |=> (core_level == '0));

    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> ack_valid);

    p_ack_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_stb |=> !ack_valid);
endmodule

bind prio_intc prio_intc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb), .ack_valid(ack_valid),
    .ack_vector(ack_vector), .core_level(core_level), .act(act), .mask_q(mask_q)
);

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] irq_req = '0;
    logic        cfg_we = 0;
    logic [5:0]  cfg_src = '0;
    logic [2:0]  cfg_level = '0, cfg_prio = '0;
    logic        mask_we = 0;
    logic [63:0] mask_wdata = '0;
    logic        ack_stb = 0;
    logic [2:0]  ack_lvl = '0;
    logic        ack_valid;
    logic [7:0]  ack_vector;
    logic [2:0]  core_level;

    int n_chk = 0, n_fail = 0;
    int m_lvl[64], m_pri[64];
    logic [63:0] m_mask = '1, m_req = '0;

    prio_intc uut (.*);

    always #4 clk = ~clk;

    task automatic check(string tag, int act_v, int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    function automatic int lvl_of(int n);
        return (n < 8) ? n : m_lvl[n];
    endfunction

    function automatic int key_of(int n);
        int r;
        if (n < 8) r = 4;
        else r = (m_pri[n] >= 4) ? m_pri[n] + 1 : m_pri[n];
        return lvl_of(n) * 16 + r;
    endfunction

    function automatic bit elig(int n);
        return n >= 1 && m_req[n] && !m_mask[n] && !m_mask[0] && lvl_of(n) != 0;
    endfunction

    // Winner for a level filter (0 = all), -1 if none.
    function automatic int winner(int flt);
        int best = -1;
        for (int n = 1; n < 64; n++)
            if (elig(n) && (flt == 0 || lvl_of(n) == flt) &&
                (best < 0 || key_of(n) > key_of(best))) best = n;
        return best;
    endfunction

    function automatic int exp_level();
        int w = winner(0);
        return (w < 0) ? 0 : lvl_of(w);
    endfunction

    task automatic wcfg(int src, int l, int p);
        @(negedge clk);
        cfg_we = 1; cfg_src = 6'(src); cfg_level = 3'(l); cfg_prio = 3'(p);
        if (src >= 8) begin m_lvl[src] = l; m_pri[src] = p; end
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wmask(logic [63:0] m);
        @(negedge clk);
        mask_we = 1; mask_wdata = m; m_mask = m;
        @(negedge clk);
        mask_we = 0;
        @(negedge clk);
    endtask

    task automatic set_req(logic [63:0] r);
        @(negedge clk);
        irq_req = r; m_req = r;
        @(negedge clk);
    endtask

    task automatic chk_core(string tag);
        check(tag, int'(core_level), exp_level());
    endtask

    task automatic do_ack(int l, string tag);
        int w;
        @(negedge clk);
        ack_stb = 1; ack_lvl = 3'(l);
        w = winner(l);
        @(negedge clk);
        check({tag, " valid"}, int'(ack_valid), 1);
        check({tag, " vector"}, int'(ack_vector), (w < 0) ? 8'h18 : 64 + w);
        ack_stb = 0;
        @(negedge clk);
        check("R10 valid drop", int'(ack_valid), 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 64; i++) begin m_lvl[i] = 0; m_pri[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 core_level", int'(core_level), 0);
        check("R1 ack_valid", int'(ack_valid), 0);
        set_req(64'hFFFF_FFFF_FFFF_FFFE);
        check("R1 mask reset blocks", int'(core_level), 0);

        // Fixed lines and midpoint slot
        wmask('0);
        set_req(64'h8);
        check("R2/R3 fixed line 3", int'(core_level), 3);
        do_ack(3, "R4 level3");
        do_ack(5, "R5 empty level");
        wcfg(20, 3, 5);
        set_req(64'h8 | (64'h1 << 20));
        do_ack(3, "R3 prio5 above fixed");
        wcfg(21, 3, 3);
        set_req(64'h8 | (64'h1 << 21));
        do_ack(3, "R3 fixed above prio3");
        wcfg(22, 3, 4);
        set_req(64'h8 | (64'h1 << 22));
        do_ack(3, "R3 prio4 above fixed");

        // Fixed lines are not reprogrammable
        wcfg(3, 7, 7);
        set_req(64'h8);
        check("R9 fixed line level kept", int'(core_level), 3);
        // Disabled programmable line
        set_req(64'h1 << 40);
        check("R9 level0 line idle", int'(core_level), 0);
        do_ack(0, "R9 level0 generic");

        // Tie rule
        wcfg(25, 6, 2);
        wcfg(30, 6, 2);
        set_req((64'h1 << 25) | (64'h1 << 30) | 64'h4);
        chk_core("R2 level6");
        do_ack(6, "R8 tie lower wins");
        wmask(64'h1 << 25);
        do_ack(6, "R7 single mask");
        do_ack(0, "R6 generic");
        wmask(64'h1);
        check("R7 global mask", int'(core_level), 0);
        do_ack(2, "R7 global mask ack");
        wmask('0);
        set_req(64'h80 | (64'h1 << 30));
        check("R3 fixed 7 top", int'(core_level), 7);
        do_ack(0, "R6 generic fixed7");

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int k = $urandom_range(0, 3);
            for (int j = 0; j < k; j++)
                wcfg($urandom_range(0, 63), $urandom_range(0, 7), $urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0)
                wmask({$urandom, $urandom} & {$urandom, $urandom} & ~64'h1);
            set_req({$urandom, $urandom});
            chk_core("R2 random level");
            do_ack($urandom_range(0, 7), "R4/R6 random ack");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule